// File: doc/BRIEF.md
# Host Port Mailbox Interface

This block is a narrow asynchronous slave port through which an external processor reaches on-chip memory and exchanges messages with the on-chip CPU. The external side drives a 2-bit port select, an active-low chip select, and active-low read and write strobes. It uses separate 16-bit write and read data buses. The strobes and the chip select pass through a flop synchronizer into the system clock domain. Each access takes effect once, on the falling edge of the synchronized strobe. The port select and write data are assumed stable for the whole strobe.

Behind the port there are four resources:
- an auto-incrementing memory pointer that drives a simple single-port RAM interface with a one-cycle read latency,
- a mailbox word in each direction, each with its own full flag,
- a set of message registers that the CPU writes to raise a host interrupt,
- a breakpoint word that the host writes and the CPU can only read.

The host reads a status word that gathers all the flags. The CPU has no path to the status word.

Top module: `hpi_mailbox_port`

## Requirements
- R1: After reset `hp_rdata`, `hp_irq`, `cpu_mbx_full`, `mem_req`, `cpu_brk` and the memory pointer are all zero.
- R2: `hp_addr` selects the port for an access: 00 data, 01 mailbox, 10 pointer, 11 status. A read result appears on `hp_rdata` and holds until the next read result.
- R3: A data-port access at an ordinary address issues exactly one memory request at the current pointer. A write drives `mem_we`=1 with the host data; a read drives `mem_we`=0 and returns the word the RAM delivers. The pointer then advances by 2.
- R4: A pointer-port write loads the pointer with bit 0 forced to 0. A pointer-port read returns the pointer.
- R5: A host mailbox write places the data on `cpu_mbx_rdata` and sets `cpu_mbx_full`. A one-cycle `cpu_mbx_rd` pulse clears the flag.
- R6: A one-cycle `cpu_mbx_wr` pulse stores a word for the host and raises `hp_irq`. A host mailbox read returns that word and clears the host-side flag.
- R7: A `cpu_msg_wr[k]` pulse stores `cpu_msg_wdata` in message register k and sets its flag, which raises `hp_irq`. Message k sits at data address 0x0144 + 4k. A host data read there returns the message and clears the flag. A host data write there changes nothing and issues no memory request.
- R8: The status word has bit 0 set when a word from the CPU awaits the host, bit 1 set when a host word awaits the CPU, and bit 2+k equal to message flag k. All other bits are zero.
- R9: A host data write at address 0x0140 loads the breakpoint word on `cpu_brk` and issues no memory request. A host data read there returns the breakpoint word.
- R10: An access takes effect on the third rising clock edge after its strobe falls. Read data appears two edges later. A strobe held low acts only once, and a strobe with `hp_cs_n` high has no effect.
- R11: When a set and a clear of the same mailbox flag land on one clock edge, the flag ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| hp_addr | input | 2 | Host port select |
| hp_cs_n | input | 1 | Host chip select, active low |
| hp_rd_n | input | 1 | Host read strobe, active low |
| hp_wr_n | input | 1 | Host write strobe, active low |
| hp_wdata | input | 16 | Host write data |
| hp_rdata | output | 16 | Host read data |
| hp_irq | output | 1 | Host interrupt request |
| mem_req | output | 1 | Memory request, one cycle |
| mem_we | output | 1 | Memory write enable |
| mem_addr | output | 16 | Memory byte address |
| mem_wdata | output | 16 | Memory write data |
| mem_rdata | input | 16 | Memory read data, valid one cycle after the request |
| cpu_mbx_wr | input | 1 | CPU writes the host-bound mailbox |
| cpu_mbx_rd | input | 1 | CPU consumes the CPU-bound mailbox |
| cpu_mbx_wdata | input | 16 | CPU mailbox data |
| cpu_mbx_rdata | output | 16 | Host-written mailbox word |
| cpu_mbx_full | output | 1 | Host word waiting for the CPU |
| cpu_msg_wr | input | 2 | Per-register message write pulses |
| cpu_msg_wdata | input | 16 | Message data |
| cpu_brk | output | 16 | Breakpoint word |

## Verification
The data path is tried with these patterns:
- a run of consecutive writes followed by reads from a reloaded pointer, which separates correct auto-increment from a stuck or doubled step;
- accesses at the breakpoint and message addresses, which show whether these locations are diverted away from memory.

Each of the four port codes is used with a distinct data pattern, so a swapped decode shows up as a wrong value or a wrong flag. A reference model, compared every cycle, catches a result or flag that moves one edge early or late.

A strobe with chip select high checks that inactive accesses are ignored. A strobe held low for many cycles checks that it acts once. A CPU mailbox pulse timed to land on the same edge as a host mailbox access checks which side wins the flag.

// File: rtl/hpi_pkg.sv
package hpi_pkg;

    // Port codes carried on the two host address lines.
    typedef enum logic [1:0] {
        PORT_DATA = 2'b00,
        PORT_MBX  = 2'b01,
        PORT_PTR  = 2'b10,
        PORT_STAT = 2'b11
    } hpi_port_e;

    // Bit positions of the synchronized control lines.
    localparam int SYNC_WR  = 0;
    localparam int SYNC_RD  = 1;
    localparam int SYNC_CS  = 2;
    localparam int SYNC_W   = 3;

endpackage

// File: rtl/hpi_strobe_sync.sv
module hpi_strobe_sync #(
    parameter int STAGES = 2,
    parameter int W      = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] raw_n,
    output logic [W-1:0] lvl_n,
    output logic [W-1:0] fall
);
    localparam int DEPTH = STAGES + 1;

    typedef struct packed {
        logic [DEPTH-1:0][W-1:0] pipe;
    } sync_t;

    sync_t st_d, st_q;

    always_comb begin
        st_d.pipe[0] = raw_n;
        for (int i = 1; i < DEPTH; i++) begin
            st_d.pipe[i] = st_q.pipe[i-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '1;
        else        st_q <= st_d;
    end

    assign lvl_n = st_q.pipe[STAGES-1];
    assign fall  = st_q.pipe[STAGES] & ~st_q.pipe[STAGES-1];

    // A falling-edge event never lasts two cycles, so a held strobe acts once.
    for (genvar k = 0; k < W; k++) begin : g_once
        p_single_event_r10: assert property (@(posedge clk) disable iff (!rst_n)
            fall[k] |=> !fall[k]);
    end

endmodule

// File: rtl/hpi_mailbox.sv
module hpi_mailbox #(
    parameter int DW      = 16,
    parameter int NUM_MSG = 2
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         host_mbx_wr,
    input  logic                         host_mbx_rd,
    input  logic [DW-1:0]                host_wdata,
    input  logic [NUM_MSG-1:0]           msg_rd,
    input  logic                         cpu_mbx_wr,
    input  logic                         cpu_mbx_rd,
    input  logic [DW-1:0]                cpu_wdata,
    input  logic [NUM_MSG-1:0]           cpu_msg_wr,
    input  logic [DW-1:0]                cpu_msg_wdata,
    output logic [DW-1:0]                to_cpu,
    output logic [DW-1:0]                to_host,
    output logic                         cpu_full,
    output logic                         host_full,
    output logic [NUM_MSG-1:0]           msg_flag,
    output logic [NUM_MSG-1:0][DW-1:0]   msg_val,
    output logic                         irq
);
    typedef struct packed {
        logic [DW-1:0]              to_cpu;
        logic [DW-1:0]              to_host;
        logic                       cpu_full;
        logic                       host_full;
        logic [NUM_MSG-1:0]         flag;
        logic [NUM_MSG-1:0][DW-1:0] msg;
    } mbx_t;

    mbx_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        // Host-to-CPU direction: the setting write outranks a CPU read.
        if (cpu_mbx_rd)  st_d.cpu_full = 1'b0;
        if (host_mbx_wr) begin
            st_d.to_cpu   = host_wdata;
            st_d.cpu_full = 1'b1;
        end
        // CPU-to-host direction: the setting write outranks a host read.
        if (host_mbx_rd) st_d.host_full = 1'b0;
        if (cpu_mbx_wr) begin
            st_d.to_host   = cpu_wdata;
            st_d.host_full = 1'b1;
        end
        for (int i = 0; i < NUM_MSG; i++) begin
            if (msg_rd[i]) st_d.flag[i] = 1'b0;
            if (cpu_msg_wr[i]) begin
                st_d.flag[i] = 1'b1;
                st_d.msg[i]  = cpu_msg_wdata;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign to_cpu    = st_q.to_cpu;
    assign to_host   = st_q.to_host;
    assign cpu_full  = st_q.cpu_full;
    assign host_full = st_q.host_full;
    assign msg_flag  = st_q.flag;
    assign msg_val   = st_q.msg;
    assign irq       = st_q.host_full | (|st_q.flag);

    p_host_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
        host_mbx_wr |=> cpu_full);
    p_cpu_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_mbx_rd && !host_mbx_wr) |=> !cpu_full);
    p_irq_raise_r6: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_mbx_wr |=> irq);
    p_host_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (host_mbx_rd && !cpu_mbx_wr) |=> !host_full);
    p_set_wins_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (host_mbx_rd && cpu_mbx_wr) |=> host_full);

    for (genvar g = 0; g < NUM_MSG; g++) begin : g_msg_chk
        p_msg_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
            cpu_msg_wr[g] |=> (msg_flag[g] && irq));
    end

endmodule

// File: rtl/hpi_access.sv
module hpi_access
    import hpi_pkg::*;
#(
    parameter int             DW         = 16,
    parameter int             AW         = 16,
    parameter int             NUM_MSG    = 2,
    parameter logic [AW-1:0]  BRK_ADDR   = 'h0140,
    parameter logic [AW-1:0]  MSG_BASE   = 'h0144,
    parameter logic [AW-1:0]  MSG_STRIDE = 'h0004
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        rd_ev,
    input  logic                        wr_ev,
    input  hpi_port_e                   port,
    input  logic [DW-1:0]               wdata,
    input  logic [DW-1:0]               mem_rdata,
    input  logic [DW-1:0]               host_word,
    input  logic [DW-1:0]               status,
    input  logic [NUM_MSG-1:0][DW-1:0]  msg_val,
    output logic                        mem_req,
    output logic                        mem_we,
    output logic [AW-1:0]               mem_addr,
    output logic [DW-1:0]               mem_wdata,
    output logic [DW-1:0]               rdata,
    output logic [DW-1:0]               brk,
    output logic                        host_mbx_wr,
    output logic                        host_mbx_rd,
    output logic [NUM_MSG-1:0]          msg_rd
);
    localparam logic [AW-1:0] ADDR_STEP  = AW'(2);
    localparam logic [AW-1:0] ALIGN_MASK = ~AW'(1);

    typedef struct packed {
        logic [AW-1:0] ptr;
        logic          req;
        logic          we;
        logic [AW-1:0] maddr;
        logic [DW-1:0] mwdata;
        logic          p1;
        logic          p1_mem;
        logic          p2;
        logic          p2_mem;
        logic [DW-1:0] lval;
        logic [DW-1:0] rdata;
        logic [DW-1:0] brk;
    } acc_t;

    acc_t st_d, st_q;

    logic [NUM_MSG-1:0] msg_hit;
    logic               brk_hit;
    logic [DW-1:0]      msg_pick;

    for (genvar g = 0; g < NUM_MSG; g++) begin : g_hit
        assign msg_hit[g] = (st_q.ptr == MSG_BASE + AW'(g) * MSG_STRIDE);
    end
    assign brk_hit = (st_q.ptr == BRK_ADDR);

    always_comb begin
        msg_pick = '0;
        for (int i = 0; i < NUM_MSG; i++) begin
            if (msg_hit[i]) msg_pick = msg_val[i];
        end
    end

    always_comb begin
        st_d        = st_q;
        st_d.req    = 1'b0;
        st_d.we     = 1'b0;
        st_d.p2     = st_q.p1;
        st_d.p2_mem = st_q.p1_mem;
        st_d.p1     = 1'b0;
        st_d.p1_mem = 1'b0;
        host_mbx_wr = 1'b0;
        host_mbx_rd = 1'b0;
        msg_rd      = '0;

        if (st_q.p2) begin
            st_d.rdata = st_q.p2_mem ? mem_rdata : st_q.lval;
        end

        if (wr_ev) begin
            unique case (port)
                PORT_DATA: begin
                    if (brk_hit) begin
                        st_d.brk = wdata;
                    end else if (msg_hit == '0) begin
                        st_d.req    = 1'b1;
                        st_d.we     = 1'b1;
                        st_d.maddr  = st_q.ptr;
                        st_d.mwdata = wdata;
                    end
                    st_d.ptr = st_q.ptr + ADDR_STEP;
                end
                PORT_MBX:  host_mbx_wr = 1'b1;
                PORT_PTR:  st_d.ptr = wdata[AW-1:0] & ALIGN_MASK;
                PORT_STAT: ;
            endcase
        end else if (rd_ev) begin
            st_d.p1 = 1'b1;
            unique case (port)
                PORT_DATA: begin
                    if (brk_hit) begin
                        st_d.lval = st_q.brk;
                    end else if (msg_hit != '0) begin
                        st_d.lval = msg_pick;
                        msg_rd    = msg_hit;
                    end else begin
                        st_d.req    = 1'b1;
                        st_d.maddr  = st_q.ptr;
                        st_d.p1_mem = 1'b1;
                    end
                    st_d.ptr = st_q.ptr + ADDR_STEP;
                end
                PORT_MBX: begin
                    st_d.lval   = host_word;
                    host_mbx_rd = 1'b1;
                end
                PORT_PTR:  st_d.lval = DW'(st_q.ptr);
                PORT_STAT: st_d.lval = status;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign mem_req   = st_q.req;
    assign mem_we    = st_q.we;
    assign mem_addr  = st_q.maddr;
    assign mem_wdata = st_q.mwdata;
    assign rdata     = st_q.rdata;
    assign brk       = st_q.brk;

    p_one_req_r10: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |=> !mem_req);
    p_ptr_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> (st_q.ptr == mem_addr + ADDR_STEP));
    p_read_return_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_we) |=> st_q.p2_mem);
    p_no_brk_write_r9: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> (mem_addr != BRK_ADDR));

endmodule

// File: rtl/hpi_mailbox_port.sv
module hpi_mailbox_port
    import hpi_pkg::*;
#(
    parameter int             DW          = 16,
    parameter int             AW          = 16,
    parameter int             NUM_MSG     = 2,
    parameter int             SYNC_STAGES = 2,
    parameter logic [AW-1:0]  BRK_ADDR    = 'h0140,
    parameter logic [AW-1:0]  MSG_BASE    = 'h0144,
    parameter logic [AW-1:0]  MSG_STRIDE  = 'h0004
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [1:0]         hp_addr,
    input  logic               hp_cs_n,
    input  logic               hp_rd_n,
    input  logic               hp_wr_n,
    input  logic [DW-1:0]      hp_wdata,
    output logic [DW-1:0]      hp_rdata,
    output logic               hp_irq,
    output logic               mem_req,
    output logic               mem_we,
    output logic [AW-1:0]      mem_addr,
    output logic [DW-1:0]      mem_wdata,
    input  logic [DW-1:0]      mem_rdata,
    input  logic               cpu_mbx_wr,
    input  logic               cpu_mbx_rd,
    input  logic [DW-1:0]      cpu_mbx_wdata,
    output logic [DW-1:0]      cpu_mbx_rdata,
    output logic               cpu_mbx_full,
    input  logic [NUM_MSG-1:0] cpu_msg_wr,
    input  logic [DW-1:0]      cpu_msg_wdata,
    output logic [DW-1:0]      cpu_brk
);
    localparam int FLAG_BASE = 2;

    logic [SYNC_W-1:0]          raw_n, lvl_n, fall;
    logic                       rd_ev, wr_ev;
    logic                       host_mbx_wr, host_mbx_rd;
    logic [NUM_MSG-1:0]         msg_rd, msg_flag;
    logic [NUM_MSG-1:0][DW-1:0] msg_val;
    logic [DW-1:0]              host_word, status;
    logic                       cpu_full, host_full;

    assign raw_n[SYNC_WR] = hp_wr_n;
    assign raw_n[SYNC_RD] = hp_rd_n;
    assign raw_n[SYNC_CS] = hp_cs_n;

    hpi_strobe_sync #(
        .STAGES (SYNC_STAGES),
        .W      (SYNC_W)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .raw_n (raw_n),
        .lvl_n (lvl_n),
        .fall  (fall)
    );

    // Write wins if both strobes fall together.
    assign wr_ev = fall[SYNC_WR] & ~lvl_n[SYNC_CS];
    assign rd_ev = fall[SYNC_RD] & ~fall[SYNC_WR] & ~lvl_n[SYNC_CS];

    always_comb begin
        status                          = '0;
        status[0]                       = host_full;
        status[1]                       = cpu_full;
        status[FLAG_BASE +: NUM_MSG]    = msg_flag;
    end

    hpi_access #(
        .DW         (DW),
        .AW         (AW),
        .NUM_MSG    (NUM_MSG),
        .BRK_ADDR   (BRK_ADDR),
        .MSG_BASE   (MSG_BASE),
        .MSG_STRIDE (MSG_STRIDE)
    ) u_access (
        .clk         (clk),
        .rst_n       (rst_n),
        .rd_ev       (rd_ev),
        .wr_ev       (wr_ev),
        .port        (hpi_port_e'(hp_addr)),
        .wdata       (hp_wdata),
        .mem_rdata   (mem_rdata),
        .host_word   (host_word),
        .status      (status),
        .msg_val     (msg_val),
        .mem_req     (mem_req),
        .mem_we      (mem_we),
        .mem_addr    (mem_addr),
        .mem_wdata   (mem_wdata),
        .rdata       (hp_rdata),
        .brk         (cpu_brk),
        .host_mbx_wr (host_mbx_wr),
        .host_mbx_rd (host_mbx_rd),
        .msg_rd      (msg_rd)
    );

    hpi_mailbox #(
        .DW      (DW),
        .NUM_MSG (NUM_MSG)
    ) u_mailbox (
        .clk           (clk),
        .rst_n         (rst_n),
        .host_mbx_wr   (host_mbx_wr),
        .host_mbx_rd   (host_mbx_rd),
        .host_wdata    (hp_wdata),
        .msg_rd        (msg_rd),
        .cpu_mbx_wr    (cpu_mbx_wr),
        .cpu_mbx_rd    (cpu_mbx_rd),
        .cpu_wdata     (cpu_mbx_wdata),
        .cpu_msg_wr    (cpu_msg_wr),
        .cpu_msg_wdata (cpu_msg_wdata),
        .to_cpu        (cpu_mbx_rdata),
        .to_host       (host_word),
        .cpu_full      (cpu_full),
        .host_full     (host_full),
        .msg_flag      (msg_flag),
        .msg_val       (msg_val),
        .irq           (hp_irq)
    );

    assign cpu_mbx_full = cpu_full;

    // An ignored strobe (chip select high) must not touch memory.
    p_cs_gate_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (fall[SYNC_WR] && lvl_n[SYNC_CS]) |=> !mem_req);

endmodule

// File: tb/hpi_mailbox_port_tb.sv
module hpi_mailbox_port_tb;
    localparam int CLK_PERIOD = 10;
    localparam logic [15:0] BRK = 16'h0140;
    localparam logic [15:0] MSG0 = 16'h0144;
    localparam logic [15:0] MSG1 = 16'h0148;
    localparam logic [15:0] COL = 16'hC011;

    logic clk = 0, rst_n = 0;
    logic [1:0] hp_addr = 0;
    logic hp_cs_n = 1, hp_rd_n = 1, hp_wr_n = 1;
    logic [15:0] hp_wdata = 0, hp_rdata;
    logic hp_irq, mem_req, mem_we;
    logic [15:0] mem_addr, mem_wdata, mem_rdata;
    logic cpu_mbx_wr = 0, cpu_mbx_rd = 0;
    logic [15:0] cpu_mbx_wdata = 0, cpu_mbx_rdata;
    logic cpu_mbx_full;
    logic [1:0] cpu_msg_wr = 0;
    logic [15:0] cpu_msg_wdata = 0, cpu_brk;

    int checks = 0, errors = 0;
    bit run = 0;

    // reference model
    logic [15:0] ram [256];
    logic [15:0] exp_mem [256];
    logic [15:0] exp_ptr = 0, exp_rdata = 0, exp_brk = 0, exp_in = 0, exp_out = 0;
    logic exp_cpu_full = 0, exp_host_full = 0;
    logic [1:0] exp_flag = 0;
    logic [15:0] exp_msg [2];

    always #(CLK_PERIOD/2) clk = ~clk;

    hpi_mailbox_port u_dut (
        .clk(clk), .rst_n(rst_n), .hp_addr(hp_addr), .hp_cs_n(hp_cs_n),
        .hp_rd_n(hp_rd_n), .hp_wr_n(hp_wr_n), .hp_wdata(hp_wdata), .hp_rdata(hp_rdata),
        .hp_irq(hp_irq), .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .cpu_mbx_wr(cpu_mbx_wr),
        .cpu_mbx_rd(cpu_mbx_rd), .cpu_mbx_wdata(cpu_mbx_wdata), .cpu_mbx_rdata(cpu_mbx_rdata),
        .cpu_mbx_full(cpu_mbx_full), .cpu_msg_wr(cpu_msg_wr), .cpu_msg_wdata(cpu_msg_wdata),
        .cpu_brk(cpu_brk)
    );

    initial begin
        for (int i = 0; i < 256; i++) begin
            ram[i] = 16'hA000 + 16'(i);
            exp_mem[i] = 16'hA000 + 16'(i);
        end
        exp_msg[0] = 0;
        exp_msg[1] = 0;
        mem_rdata = 0;
    end

    always @(posedge clk) begin
        if (mem_req) begin
            if (mem_we) ram[mem_addr[8:1]] <= mem_wdata;
            else        mem_rdata <= ram[mem_addr[8:1]];
        end
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] want);
        checks++;
        if (act !== want) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, want);
        end
    endtask

    // per-cycle comparison against the model
    always @(negedge clk) begin
        if (run) begin
            #1;
            check("R6 hp_irq", 32'(hp_irq), 32'(exp_host_full | exp_flag[0] | exp_flag[1]));
            check("R5 cpu_mbx_full", 32'(cpu_mbx_full), 32'(exp_cpu_full));
            check("R5 cpu_mbx_rdata", 32'(cpu_mbx_rdata), 32'(exp_in));
            check("R2 hp_rdata", 32'(hp_rdata), 32'(exp_rdata));
            check("R9 cpu_brk", 32'(cpu_brk), 32'(exp_brk));
        end
    end

    task automatic strobe_begin(input bit wr, input logic [1:0] port, input logic [15:0] data,
                                input bit cs_en, input bit collide);
        @(negedge clk);
        hp_addr = port; hp_wdata = data; hp_cs_n = !cs_en;
        @(negedge clk);
        if (wr) hp_wr_n = 0; else hp_rd_n = 0;
        @(negedge clk);
        @(negedge clk);
        if (collide) begin
            cpu_mbx_wr = 1; cpu_mbx_rd = 1; cpu_mbx_wdata = COL;
        end
        @(negedge clk);
        cpu_mbx_wr = 0; cpu_mbx_rd = 0;
    endtask

    task automatic strobe_end(input int hold);
        repeat (hold) @(negedge clk);
        hp_rd_n = 1; hp_wr_n = 1;
        repeat (3) @(negedge clk);
        hp_cs_n = 1;
        @(negedge clk);
    endtask

    task automatic apply_collide(input bit host_mbx_write);
        exp_host_full = 1;
        exp_out = COL;
        if (!host_mbx_write) exp_cpu_full = 0;
    endtask

    task automatic host_write(input logic [1:0] port, input logic [15:0] data,
                              input int hold = 3, input bit cs_en = 1, input bit collide = 0);
        strobe_begin(1, port, data, cs_en, collide);
        if (cs_en) begin
            case (port)
                2'b00: begin
                    if (exp_ptr == BRK) begin
                        check("R9 no mem_req at breakpoint", 32'(mem_req), 0);
                        exp_brk = data;
                    end else if (exp_ptr == MSG0 || exp_ptr == MSG1) begin
                        check("R7 no mem_req at message", 32'(mem_req), 0);
                    end else begin
                        check("R3 mem_req", 32'(mem_req), 1);
                        check("R3 mem_we", 32'(mem_we), 1);
                        check("R3 mem_addr", 32'(mem_addr), 32'(exp_ptr));
                        check("R3 mem_wdata", 32'(mem_wdata), 32'(data));
                        exp_mem[exp_ptr[8:1]] = data;
                    end
                    exp_ptr = exp_ptr + 16'd2;
                end
                2'b01: begin exp_cpu_full = 1; exp_in = data; end
                2'b10: exp_ptr = data & 16'hFFFE;
                default: ;
            endcase
        end else begin
            check("R10 no mem_req with cs high", 32'(mem_req), 0);
        end
        if (collide) apply_collide(port == 2'b01);
        strobe_end(hold);
    endtask

    task automatic host_read(input logic [1:0] port, input logic [15:0] want,
                             input string req, input bit collide = 0);
        strobe_begin(0, port, 16'h0, 1, collide);
        case (port)
            2'b00: begin
                if (exp_ptr == MSG0) exp_flag[0] = 0;
                else if (exp_ptr == MSG1) exp_flag[1] = 0;
                else if (exp_ptr != BRK) begin
                    check("R3 read mem_req", 32'(mem_req), 1);
                    check("R3 read mem_we", 32'(mem_we), 0);
                    check("R3 read mem_addr", 32'(mem_addr), 32'(exp_ptr));
                end
                exp_ptr = exp_ptr + 16'd2;
            end
            2'b01: exp_host_full = 0;
            default: ;
        endcase
        if (collide) apply_collide(0);
        @(negedge clk);
        @(negedge clk);
        exp_rdata = want;
        check(req, 32'(hp_rdata), 32'(want));
        strobe_end(1);
    endtask

    task automatic cpu_send(input logic [15:0] d);
        @(negedge clk); cpu_mbx_wr = 1; cpu_mbx_wdata = d;
        @(negedge clk); cpu_mbx_wr = 0;
        exp_host_full = 1; exp_out = d;
    endtask

    task automatic cpu_take();
        @(negedge clk); cpu_mbx_rd = 1;
        @(negedge clk); cpu_mbx_rd = 0;
        exp_cpu_full = 0;
    endtask

    task automatic cpu_msg(input int k, input logic [15:0] d);
        @(negedge clk); cpu_msg_wr[k] = 1; cpu_msg_wdata = d;
        @(negedge clk); cpu_msg_wr = 0;
        exp_flag[k] = 1; exp_msg[k] = d;
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        errors++; checks++;
        $display("FAIL R10 watchdog: actual=hung expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        check("R1 hp_rdata", 32'(hp_rdata), 0);
        check("R1 hp_irq", 32'(hp_irq), 0);
        check("R1 cpu_mbx_full", 32'(cpu_mbx_full), 0);
        check("R1 mem_req", 32'(mem_req), 0);
        check("R1 cpu_brk", 32'(cpu_brk), 0);
        run = 1;
        host_read(2'b10, 16'h0000, "R1 pointer after reset");

        // R4 pointer load with bit 0 cleared
        host_write(2'b10, 16'h0011);
        host_read(2'b10, 16'h0010, "R4 pointer readback");

        // R3 sequential writes then reads
        host_write(2'b00, 16'h1111);
        host_write(2'b00, 16'h2222);
        host_read(2'b10, 16'h0014, "R3 pointer after two writes");
        host_write(2'b10, 16'h0010);
        host_read(2'b00, 16'h1111, "R3 read first word");
        host_read(2'b00, 16'h2222, "R3 read second word");
        host_read(2'b00, 16'hA00A, "R3 read untouched word");

        // R5 host to CPU mailbox, R8 status bit 1
        host_write(2'b01, 16'hBEEF);
        host_read(2'b11, 16'h0002, "R8 status cpu-bound full");
        cpu_take();
        check("R5 flag cleared by cpu read", 32'(cpu_mbx_full), 0);

        // R6 CPU to host mailbox
        cpu_send(16'h5A5A);
        check("R6 irq raised", 32'(hp_irq), 1);
        host_read(2'b11, 16'h0001, "R8 status host-bound full");
        host_read(2'b01, 16'h5A5A, "R6 mailbox value");
        check("R6 irq cleared", 32'(hp_irq), 0);

        // R7 messages
        cpu_msg(1, 16'h7777);
        cpu_msg(0, 16'h1234);
        host_read(2'b11, 16'h000C, "R8 status both messages");
        host_write(2'b10, MSG1);
        host_write(2'b00, 16'h9999);
        check("R7 ignored write leaves memory", 32'(ram[MSG1[8:1]]), 32'(exp_mem[MSG1[8:1]]));
        host_write(2'b10, MSG1);
        host_read(2'b00, 16'h7777, "R7 message 1 value");
        host_write(2'b10, MSG0);
        host_read(2'b00, 16'h1234, "R7 message 0 value");
        check("R7 irq cleared", 32'(hp_irq), 0);

        // R9 breakpoint
        host_write(2'b10, BRK);
        host_write(2'b00, 16'hCAFE);
        check("R9 cpu_brk", 32'(cpu_brk), 32'hCAFE);
        check("R9 memory untouched", 32'(ram[BRK[8:1]]), 32'(exp_mem[BRK[8:1]]));
        host_write(2'b10, BRK);
        host_read(2'b00, 16'hCAFE, "R9 breakpoint read");

        // R10 chip select high ignored; held strobe acts once
        host_write(2'b01, 16'h1357, 3, 0);
        check("R10 cs high no mailbox", 32'(cpu_mbx_full), 0);
        host_write(2'b10, 16'h0020);
        host_write(2'b00, 16'hABCD, 20);
        host_read(2'b10, 16'h0022, "R10 single step for long strobe");
        host_write(2'b10, 16'h0020);
        host_read(2'b00, 16'hABCD, "R10 long-strobe data");

        // R11 set wins over clear on the same edge
        host_write(2'b01, 16'h4444, 3, 1, 1);
        check("R11 cpu-bound flag kept", 32'(cpu_mbx_full), 1);
        host_read(2'b01, COL, "R11 mailbox read during cpu write", 1);
        check("R11 host-bound flag kept", 32'(hp_irq), 1);
        host_read(2'b01, COL, "R6 mailbox drain");
        check("R6 irq low after drain", 32'(hp_irq), 0);

        repeat (3) @(negedge clk);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule